// File: doc/BRIEF.md
# DDR2 Auto-Refresh Scheduler

This block paces the auto-refresh traffic for one DDR2 memory device. A free-running interval timer adds one refresh credit at each refresh interval. The interval is the long one while the device case is in the normal range (up to 85 °C) and half as long while the hot flag says the case is between 85 °C and 95 °C. Both intervals are given in picoseconds and turned into whole clock cycles by rounding up.

Credits let refreshes be put off while the command arbiter reports the memory busy. Once eight refreshes are owed, the scheduler stops deferring. Whenever it acts, it first raises a precharge-all request. After that request is granted, it waits out the all-bank precharge time, which is one cycle longer than the single-bank precharge time given on an input. Only then does it raise the refresh request. Each request stays up until the arbiter grants it. A granted refresh pays back one credit.

Top module: `ddr2_refresh_sched`

## Requirements
- R1: With the hot flag low, credits are added every ceil(TREFI_NORM_PS / TCK_PS) cycles (975 cycles at the defaults of 7 800 000 ps and 8000 ps). With busy low and grant high, successive rising edges of the precharge-all request are exactly that many cycles apart.
- R2: With the hot flag high, the credit period is ceil(TREFI_HOT_PS / TCK_PS) cycles (488 at the defaults).
- R3: The credit count never exceeds MAX_CREDIT (8). Ticks that arrive at the cap are dropped. With the cap reached, a precharge-all request is raised even while busy is high. Under permanent busy, the first precharge-all request rises exactly 7 intervals later than it does with busy low.
- R4: If a precharge-all request is granted in cycle c, the refresh request first goes high in cycle c + trp + 1. Here trp is the value on the precharge-time input in the granting cycle.
- R5: Once raised, a request stays high in every following cycle until a cycle in which grant is high.
- R6: The two requests are never high together. Every refresh request is preceded by exactly one granted precharge-all request.
- R7: During reset and afterwards, both requests stay low while no credit is held.
- R8: While busy is high and fewer than MAX_CREDIT credits are held, no new precharge-all request starts. When busy falls, every deferred credit is turned into one refresh.
- R9: Each granted refresh removes one credit. With credits drained and no new tick, both requests stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hot_i | input | 1 | High when the case temperature is in the 85 °C to 95 °C range |
| busy_i | input | 1 | Arbiter reports the memory busy; defers refresh below the cap |
| grant_i | input | 1 | Arbiter accepts the request that is high in this cycle |
| trp_cycles_i | input | TRP_W | Single-bank precharge time in clock cycles |
| pre_all_req_o | output | 1 | Request for a precharge-all command |
| ref_req_o | output | 1 | Request for an auto-refresh command |

## Verification
The properties assume that the arbiter treats grant as meaningful only while a request is high. They also assume that busy and grant are steady for a whole clock cycle, and that the precharge time may change in any cycle because the block samples it only at the precharge grant. The stimulus keeps to this. All inputs change half a cycle away from the sampling edge. In the random phase the precharge time is redrawn every cycle in the range 0 to 12, so refresh spacing is checked against the value present at each grant. Busy is held low for most cycles, so postponement and forced refresh both occur without the bench having to predict credit totals.

// File: rtl/ddr2_ref_pkg.sv
package ddr2_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT,
    ST_REF
  } ref_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/ref_rst_sync.sv
module ref_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int CW       = 10,
  parameter int LIM_NORM = 975,
  parameter int LIM_HOT  = 488
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  output logic tick
);

  logic [CW-1:0] cnt_q, cnt_d, last_val;

  // a counter already past a shortened limit wraps at once
  always_comb begin
    last_val = hot ? CW'(LIM_HOT - 1) : CW'(LIM_NORM - 1);
    tick     = (cnt_q >= last_val);
    cnt_d    = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ref_credit_ctr.sv
module ref_credit_ctr #(
  parameter int MAXC = 8,
  parameter int KW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic [KW-1:0] credit,
  output logic          avail,
  output logic          full
);

  logic [KW-1:0] cred_q, cred_d;
  logic          cred_en;

  assign avail  = (cred_q != '0);
  assign full   = (cred_q == KW'(MAXC));
  assign credit = cred_q;

  always_comb begin
    cred_d  = cred_q;
    cred_en = 1'b0;
    unique case ({tick, take})
      2'b10: if (!full) begin
        cred_d  = cred_q + KW'(1);
        cred_en = 1'b1;
      end
      2'b01: if (avail) begin
        cred_d  = cred_q - KW'(1);
        cred_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cred_q <= '0;
    else if (cred_en) cred_q <= cred_d;
  end

endmodule

// File: rtl/ref_cmd_fsm.sv
module ref_cmd_fsm
  import ddr2_ref_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail,
  input  logic          full,
  input  logic          busy,
  input  logic          grant,
  input  logic [TW-1:0] trp,
  output logic          pre_req,
  output logic          ref_req,
  output logic          in_wait,
  output logic          take
);

  ref_state_e    state_q, state_d;
  logic [TW-1:0] wcnt_q, wcnt_d;
  logic          wcnt_en;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (avail && (!busy || full)) state_d = ST_PRE;
      ST_PRE: if (grant) begin
        if (trp == '0) begin
          state_d = ST_REF;
        end else begin
          state_d = ST_WAIT;
          wcnt_d  = trp;
          wcnt_en = 1'b1;
        end
      end
      // trp cycles here plus the grant cycle give trp + 1
      ST_WAIT: if (wcnt_q == TW'(1)) begin
        state_d = ST_REF;
      end else begin
        wcnt_d  = wcnt_q - TW'(1);
        wcnt_en = 1'b1;
      end
      ST_REF: if (grant) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

  assign pre_req = (state_q == ST_PRE);
  assign ref_req = (state_q == ST_REF);
  assign in_wait = (state_q == ST_WAIT);
  assign take    = ref_req && grant;

endmodule

// File: rtl/ddr2_refresh_sched.sv
module ddr2_refresh_sched
  import ddr2_ref_pkg::*;
#(
  parameter int TCK_PS        = 8000,
  parameter int TREFI_NORM_PS = 7_800_000,
  parameter int TREFI_HOT_PS  = 3_900_000,
  parameter int MAX_CREDIT    = 8,
  parameter int TRP_W         = 5,
  parameter int RST_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hot_i,
  input  logic             busy_i,
  input  logic             grant_i,
  input  logic [TRP_W-1:0] trp_cycles_i,
  output logic             pre_all_req_o,
  output logic             ref_req_o
);

  localparam int LIM_NORM = ceil_div(TREFI_NORM_PS, TCK_PS);
  localparam int LIM_HOT  = ceil_div(TREFI_HOT_PS, TCK_PS);
  localparam int LIM_MAX  = (LIM_NORM > LIM_HOT) ? LIM_NORM : LIM_HOT;
  localparam int CNT_W    = $clog2(LIM_MAX + 1);
  localparam int KW       = $clog2(MAX_CREDIT + 1);

  logic          rst_sync_n;
  logic          tick, take, avail, full, wait_st;
  logic [KW-1:0] credit_q;

  ref_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ref_interval_timer #(
    .CW       (CNT_W),
    .LIM_NORM (LIM_NORM),
    .LIM_HOT  (LIM_HOT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hot   (hot_i),
    .tick  (tick)
  );

  ref_credit_ctr #(.MAXC(MAX_CREDIT), .KW(KW)) u_credit (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .take   (take),
    .credit (credit_q),
    .avail  (avail),
    .full   (full)
  );

  ref_cmd_fsm #(.TW(TRP_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .avail   (avail),
    .full    (full),
    .busy    (busy_i),
    .grant   (grant_i),
    .trp     (trp_cycles_i),
    .pre_req (pre_all_req_o),
    .ref_req (ref_req_o),
    .in_wait (wait_st),
    .take    (take)
  );

endmodule

// File: rtl/ref_sched_checker.sv
module ref_sched_checker #(
  parameter int MAXC = 8,
  parameter int KW   = 4
) (
  input logic          clk,
  input logic          srst_n,
  input logic          pre,
  input logic          refr,
  input logic          grant,
  input logic          busy,
  input logic [KW-1:0] credit,
  input logic          in_wait
);

  logic idle;
  assign idle = !pre && !refr && !in_wait;

  p_excl_req_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !(pre && refr));

  p_pre_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    pre && !grant |=> pre);

  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    refr && !grant |=> refr);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!srst_n)
    credit <= KW'(MAXC));

  p_forced_r3: assert property (@(posedge clk) disable iff (!srst_n)
    idle && credit == KW'(MAXC) |=> pre);

  p_ref_after_pre_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(refr) |-> $past(pre) || $past(in_wait));

  p_no_credit_quiet_r7: assert property (@(posedge clk) disable iff (!srst_n)
    idle && credit == '0 |=> !pre);

  p_defer_r8: assert property (@(posedge clk) disable iff (!srst_n)
    idle && busy && credit != '0 && credit != KW'(MAXC) |=> !pre);

  p_go_r8: assert property (@(posedge clk) disable iff (!srst_n)
    idle && !busy && credit != '0 |=> pre);

  p_take_r9: assert property (@(posedge clk) disable iff (!srst_n)
    refr && grant |=> credit <= $past(credit));

endmodule

bind ddr2_refresh_sched ref_sched_checker #(.MAXC(MAX_CREDIT), .KW(KW)) u_chk (
  .clk     (clk),
  .srst_n  (rst_sync_n),
  .pre     (pre_all_req_o),
  .refr    (ref_req_o),
  .grant   (grant_i),
  .busy    (busy_i),
  .credit  (credit_q),
  .in_wait (wait_st)
);

// File: tb/ddr2_refresh_sched_test.sv
`timescale 1ns/1ps
module ddr2_refresh_sched_test;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int TCK   = 8000;
  localparam int INT_N = cdiv(7_800_000, TCK);
  localparam int INT_H = cdiv(3_900_000, TCK);

  logic       clk, rst_n, hot_i, busy_i, grant_i;
  logic [4:0] trp_i;
  logic       pre_w, ref_w;

  ddr2_refresh_sched uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .hot_i         (hot_i),
    .busy_i        (busy_i),
    .grant_i       (grant_i),
    .trp_cycles_i  (trp_i),
    .pre_all_req_o (pre_w),
    .ref_req_o     (ref_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0, n_bad = 0, ncyc = 0, wd = 0;
  int t_pre = 0, trp_at = 0, pre_acc = 0, ref_acc = 0;
  int last_rise = -1, first_rise = -1, period_exp = 0, t1 = 0;
  int trp_sel = 5;
  bit trp_rand = 0, pre_prev = 0, ref_prev = 0, hold_pre = 0, hold_ref = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !done) begin
      chk(0, "watchdog", wd, 190000);
      finish_run();
    end
  end

  // one cycle: sample outputs at negedge, then drive inputs
  task automatic cyc(input bit b, input bit g);
    @(negedge clk);
    ncyc++;
    if (hold_pre) chk(pre_w, "R5 precharge-all held", pre_w, 1);
    if (hold_ref) chk(ref_w, "R5 refresh held", ref_w, 1);
    if (pre_w && ref_w) chk(0, "R6 exclusive requests", 1, 0);
    if (pre_w && !pre_prev) begin
      if (period_exp != 0 && last_rise >= 0)
        chk(ncyc - last_rise == period_exp, (period_exp == INT_H) ? "R2 hot period" : "R1 normal period",
            ncyc - last_rise, period_exp);
      last_rise = ncyc;
      if (first_rise < 0) first_rise = ncyc;
    end
    if (ref_w && !ref_prev) begin
      chk(ncyc - t_pre == trp_at + 1, "R4 precharge-to-refresh spacing", ncyc - t_pre, trp_at + 1);
      chk(pre_acc == ref_acc + 1, "R6 refresh preceded by precharge-all", pre_acc, ref_acc + 1);
    end
    busy_i  = b;
    grant_i = g;
    trp_i   = trp_rand ? 5'($urandom_range(0, 12)) : 5'(trp_sel);
    if (pre_w && g) begin
      pre_acc++;
      t_pre  = ncyc;
      trp_at = int'(trp_i);
    end
    if (ref_w && g) ref_acc++;
    hold_pre = pre_w && !g;
    hold_ref = ref_w && !g;
    pre_prev = pre_w;
    ref_prev = ref_w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    busy_i = 1'b0;
    grant_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pre_w && !ref_w, "R7 reset state", {30'd0, pre_w, ref_w}, 0);
    rst_n = 1'b1;
    ncyc = 0; pre_acc = 0; ref_acc = 0; last_rise = -1; first_rise = -1;
    period_exp = 0; pre_prev = 0; ref_prev = 0; hold_pre = 0; hold_ref = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; hot_i = 1'b0; busy_i = 1'b0; grant_i = 1'b0; trp_i = 5'd5;

    // R1 and R7: free running, normal range
    do_reset();
    trp_sel = 5;
    repeat (INT_N - 10) cyc(0, 1);
    chk(pre_acc == 0, "R7 quiet before first interval", pre_acc, 0);
    while (first_rise < 0 && ncyc < 2 * INT_N) cyc(0, 1);
    t1 = first_rise;
    period_exp = INT_N;
    repeat (3 * INT_N + 20) cyc(0, 1);

    // R2: hot range, varied precharge time for R4
    trp_rand = 1;
    hot_i = 1'b1; period_exp = 0;
    repeat (2 * INT_N) cyc(0, 1);
    period_exp = INT_H;
    repeat (4 * INT_H + 20) cyc(0, 1);
    hot_i = 1'b0; period_exp = 0;
    repeat (2 * INT_N) cyc(0, 1);
    period_exp = INT_N;
    repeat (2 * INT_N + 20) cyc(0, 1);
    trp_rand = 0;

    // R8 and R9: postpone three, then drain
    do_reset();
    trp_sel = 3;
    repeat (3 * INT_N + INT_N / 2) cyc(1, 1);
    chk(pre_acc == 0, "R8 busy defers", pre_acc, 0);
    repeat (INT_N * 4 / 10) cyc(0, 1);
    chk(ref_acc == 3, "R8 deferred refreshes issued", ref_acc, 3);
    chk(!pre_w && !ref_w, "R9 drained credits quiet", {30'd0, pre_w, ref_w}, 0);

    // R3: forced refresh timing under permanent busy
    do_reset();
    trp_sel = 0;
    while (first_rise < 0 && ncyc < 9 * INT_N) cyc(1, 1);
    chk(first_rise - t1 == 7 * INT_N, "R3 forced after cap", first_rise - t1, 7 * INT_N);
    period_exp = INT_N;
    repeat (3 * INT_N + 20) cyc(1, 1);

    // R3: saturation, excess ticks dropped
    do_reset();
    trp_sel = 3;
    repeat (10 * INT_N + INT_N / 2) cyc(1, 0);
    chk(pre_w == 1'b1, "R3 forced request while busy", pre_w, 1);
    chk(ref_acc == 0, "R3 nothing granted yet", ref_acc, 0);
    repeat (INT_N * 4 / 10) cyc(0, 1);
    chk(ref_acc == 8, "R3 capped credit count", ref_acc, 8);

    // random mix
    do_reset();
    trp_rand = 1;
    repeat (20 * INT_N) cyc($urandom_range(0, 9) < 3, $urandom_range(0, 9) < 6);
    repeat (INT_N / 2) cyc(0, 1);
    chk(ref_acc > 0 && pre_acc - ref_acc <= 1, "R6 random balance", pre_acc - ref_acc, 0);

    finish_run();
  end

endmodule